// File: doc/BRIEF.md
# JESD204B Link Synchronization Sequencer

This block is the link-layer sequencer for one lane of a JESD204B-style transmitter. It works at the octet clock and emits one octet per cycle, together with a flag that marks control characters for the 8b/10b encoder that follows it. While the receiver holds its sync request, the lane sends comma characters so that the receiver can lock onto code groups. Once the request is released, the block waits for a local multiframe clock (LMFC) boundary and an optional extra delay. It then sends the initial lane alignment sequence (ILA) and after that passes transport-layer octets straight through.

An internal LMFC counter tracks the octet position inside the frame and the frame position inside the multiframe. A SYSREF pulse realigns it, either to zero or, when forcing is enabled, to a preset frame index. The frame size is selectable and the multiframe length is programmable. A skip option goes from commas straight to user data. A comma variant sends the two-octet code word 0xBC50 in place of 0xBCBC.

The state machine has four states:
- ST_SYNC: commas.
- ST_WAIT: commas while counting LMFC boundaries.
- ST_ILA: the four alignment multiframes.
- ST_DATA: pass-through.

Its transitions are:
- SYNC_TO_WAIT: request released, ILA enabled.
- SYNC_TO_DATA: request released, ILA skipped.
- WAIT_TO_ILA: last octet before a boundary with the delay count at zero.
- ILA_TO_DATA: last octet of the fourth ILA multiframe.
- ANY_TO_SYNC: request asserted, which takes priority everywhere.

Top module: `jesd_link_seq`

## Requirements
- R1: While `rst` is high, and on the first output after reset, the output is the comma 0xBC with `tx_is_k`=1, and the machine is in ST_SYNC.
- R2: While the sync request is high, every output octet is a comma 0xBC flagged as control. When `cfg_alt_comma`=1, octets in odd positions within the frame are instead 0x50 with the flag clear.
- R3: A sync request asserted in any state moves the machine to ST_SYNC on the next edge. Commas appear at the output one cycle after that.
- R4: A frame is F octets, with F=2 when `cfg_f_quad`=0 and F=4 when it is 1. A multiframe is K frames. K is `cfg_k_m1`+1, raised to a floor of 9 when F=2 and 8 when F=4.
- R5: A cycle with `sysref` high sets the octet index to 0. It sets the frame index to 0, or to `cfg_lmfc_init` when `cfg_lmfc_force`=1.
- R6: After the request drops, commas continue until the first LMFC boundary. The ILA then begins after a further `cfg_ila_dly` (0..3) whole multiframes.
- R7: The ILA lasts four multiframes. Each starts with 0x1C (K28.0, control) at octet position 0 and ends with 0x7C (K28.3, control) at position F·K−1. Every other filler octet equals its octet position within the multiframe, with the flag clear.
- R8: In the second ILA multiframe, position 1 is 0x9C (K28.4, control), and positions 2..15 hold the 14 configuration octets with the flag clear. These are, in order: device id, lane id, F−1, K−1, nine zero octets, and the modulo-256 sum of the first four.
- R9: After the ILA, each output octet is the `in_octet` value sampled one edge earlier, with the flag clear.
- R10: With `cfg_ila_skip`=1, releasing the request leads straight to user data with no ILA and no boundary wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 1 | Receiver sync request, active high |
| sysref | input | 1 | LMFC alignment strobe |
| in_octet | input | 8 | Transport-layer octet |
| cfg_f_quad | input | 1 | 0: F=2, 1: F=4 |
| cfg_k_m1 | input | 5 | Frames per multiframe minus one |
| cfg_lmfc_force | input | 1 | Load preset frame index on SYSREF |
| cfg_lmfc_init | input | 5 | Preset frame index |
| cfg_ila_dly | input | 2 | Extra multiframes before ILA |
| cfg_ila_skip | input | 1 | Skip the ILA |
| cfg_alt_comma | input | 1 | Use 0xBC50 code word |
| cfg_dev_id | input | 8 | Device id config octet |
| cfg_lane_id | input | 5 | Lane id config octet |
| tx_octet | output | 8 | Output octet |
| tx_is_k | output | 1 | Output octet is a control character |

## Verification
The bench targets the places where an off-by-one is easy to make:
- ILA start: a design that counts the boundary at the wrong cycle opens the ILA one octet, or one multiframe, early or late. Every ramp position then mismatches.
- Multiframe floor: if the floor on K is missing, the end marker lands on a configuration octet.
- Forced preset on SYSREF: if the preset is ignored, the ILA is shifted in time.
- Sync reassertion in mid-ILA: the machine must abandon the sequence at once and later restart it from multiframe one, not resume it.
- Skip and alternate-comma options: with skip, the first data octet must follow the last comma with no gap. With the alternate comma, the half-word must line up with the frame.

// File: rtl/jls_pkg.sv
package jls_pkg;

    typedef enum logic [1:0] {
        ST_SYNC = 2'd0,
        ST_WAIT = 2'd1,
        ST_ILA  = 2'd2,
        ST_DATA = 2'd3
    } jls_state_e;

    localparam logic [7:0] CH_COMMA    = 8'hBC;
    localparam logic [7:0] CH_ALT_TAIL = 8'h50;
    localparam logic [7:0] CH_MF_START = 8'h1C;
    localparam logic [7:0] CH_MF_END   = 8'h7C;
    localparam logic [7:0] CH_CFG_MARK = 8'h9C;

endpackage

// File: rtl/jls_lmfc.sv
module jls_lmfc #(
    parameter int FRM_W     = 5,
    parameter int KMIN_PAIR = 9,
    parameter int KMIN_QUAD = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sysref,
    input  logic             f_quad,
    input  logic             force_en,
    input  logic [FRM_W-1:0] init_val,
    input  logic [FRM_W-1:0] k_m1_prog,
    output logic [1:0]       oct_idx,
    output logic [FRM_W-1:0] frm_idx,
    output logic [FRM_W-1:0] k_m1_eff,
    output logic             mf_last
);
    localparam logic [FRM_W-1:0] KM1_PAIR = FRM_W'(KMIN_PAIR - 1);
    localparam logic [FRM_W-1:0] KM1_QUAD = FRM_W'(KMIN_QUAD - 1);

    logic [1:0]       f_m1;
    logic [FRM_W-1:0] k_floor;
    logic             last_oct;
    logic             last_frm;

    assign f_m1     = f_quad ? 2'd3 : 2'd1;
    assign k_floor  = f_quad ? KM1_QUAD : KM1_PAIR;
    assign k_m1_eff = (k_m1_prog < k_floor) ? k_floor : k_m1_prog;
    assign last_oct = (oct_idx >= f_m1);
    assign last_frm = (frm_idx >= k_m1_eff);
    assign mf_last  = last_oct && last_frm;

    always_ff @(posedge clk) begin
        if (rst) begin
            oct_idx <= '0;
            frm_idx <= '0;
        end else if (sysref) begin
            oct_idx <= '0;
            frm_idx <= force_en ? init_val : '0;
        end else if (last_oct) begin
            oct_idx <= '0;
            frm_idx <= last_frm ? '0 : frm_idx + 1'b1;
        end else begin
            oct_idx <= oct_idx + 1'b1;
        end
    end
endmodule

// File: rtl/jls_ila_gen.sv
module jls_ila_gen #(
    parameter int FRM_W   = 5,
    parameter int LANE_W  = 5,
    parameter int CFG_LEN = 14
) (
    input  logic [1:0]        mf_idx,
    input  logic [1:0]        oct_idx,
    input  logic [FRM_W-1:0]  frm_idx,
    input  logic [FRM_W-1:0]  k_m1_eff,
    input  logic              f_quad,
    input  logic              mf_last,
    input  logic [7:0]        dev_id,
    input  logic [LANE_W-1:0] lane_id,
    output logic [7:0]        ila_octet,
    output logic              ila_is_k
);
    import jls_pkg::*;

    localparam int POS_W = FRM_W + 2;
    localparam int IDX_W = $clog2(CFG_LEN);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] cfg_off;
    logic [IDX_W-1:0] cfg_idx;
    logic             in_cfg;
    logic [7:0]       cfg_tbl [CFG_LEN];
    logic [7:0]       csum;

    assign pos     = f_quad ? {frm_idx, oct_idx} : {1'b0, frm_idx, oct_idx[0]};
    assign cfg_off = pos - POS_W'(2);
    assign cfg_idx = IDX_W'(cfg_off);
    assign in_cfg  = (mf_idx == 2'd1) && (pos >= POS_W'(2)) && (pos < POS_W'(2 + CFG_LEN));

    always_comb begin
        for (int i = 0; i < CFG_LEN; i++) cfg_tbl[i] = 8'h00;
        cfg_tbl[0] = dev_id;
        cfg_tbl[1] = 8'(lane_id);
        cfg_tbl[2] = f_quad ? 8'd3 : 8'd1;
        cfg_tbl[3] = 8'(k_m1_eff);
        csum = 8'h00;
        for (int i = 0; i < CFG_LEN - 1; i++) csum = csum + cfg_tbl[i];
        cfg_tbl[CFG_LEN-1] = csum;
    end

    always_comb begin
        if (pos == '0) begin
            ila_octet = CH_MF_START;
            ila_is_k  = 1'b1;
        end else if (mf_last) begin
            ila_octet = CH_MF_END;
            ila_is_k  = 1'b1;
        end else if ((mf_idx == 2'd1) && (pos == POS_W'(1))) begin
            ila_octet = CH_CFG_MARK;
            ila_is_k  = 1'b1;
        end else if (in_cfg) begin
            ila_octet = cfg_tbl[cfg_idx];
            ila_is_k  = 1'b0;
        end else begin
            ila_octet = 8'(pos);
            ila_is_k  = 1'b0;
        end
    end
endmodule

// File: rtl/jesd_link_seq.sv
module jesd_link_seq #(
    parameter int FRM_W   = 5,
    parameter int LANE_W  = 5,
    parameter int DLY_W   = 2,
    parameter int ILA_MF  = 4,
    parameter int CFG_LEN = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_req,
    input  logic              sysref,
    input  logic [7:0]        in_octet,
    input  logic              cfg_f_quad,
    input  logic [FRM_W-1:0]  cfg_k_m1,
    input  logic              cfg_lmfc_force,
    input  logic [FRM_W-1:0]  cfg_lmfc_init,
    input  logic [DLY_W-1:0]  cfg_ila_dly,
    input  logic              cfg_ila_skip,
    input  logic              cfg_alt_comma,
    input  logic [7:0]        cfg_dev_id,
    input  logic [LANE_W-1:0] cfg_lane_id,
    output logic [7:0]        tx_octet,
    output logic              tx_is_k
);
    import jls_pkg::*;

    localparam int MF_W = $clog2(ILA_MF);

    jls_state_e       st_q, st_d;
    logic [DLY_W-1:0] dly_q, dly_d;
    logic [MF_W-1:0]  mf_q, mf_d;
    logic [1:0]       oct_idx;
    logic [FRM_W-1:0] frm_idx;
    logic [FRM_W-1:0] k_m1_eff;
    logic             mf_last;
    logic [7:0]       ila_octet;
    logic             ila_is_k;
    logic [7:0]       oct_d;
    logic             isk_d;

    jls_lmfc #(.FRM_W(FRM_W)) u_lmfc (
        .clk       (clk),
        .rst       (rst),
        .sysref    (sysref),
        .f_quad    (cfg_f_quad),
        .force_en  (cfg_lmfc_force),
        .init_val  (cfg_lmfc_init),
        .k_m1_prog (cfg_k_m1),
        .oct_idx   (oct_idx),
        .frm_idx   (frm_idx),
        .k_m1_eff  (k_m1_eff),
        .mf_last   (mf_last)
    );

    jls_ila_gen #(.FRM_W(FRM_W), .LANE_W(LANE_W), .CFG_LEN(CFG_LEN)) u_ila (
        .mf_idx    (2'(mf_q)),
        .oct_idx   (oct_idx),
        .frm_idx   (frm_idx),
        .k_m1_eff  (k_m1_eff),
        .f_quad    (cfg_f_quad),
        .mf_last   (mf_last),
        .dev_id    (cfg_dev_id),
        .lane_id   (cfg_lane_id),
        .ila_octet (ila_octet),
        .ila_is_k  (ila_is_k)
    );

    // Next-state logic; a sync request overrides every state.
    always_comb begin
        st_d  = st_q;
        dly_d = dly_q;
        mf_d  = mf_q;
        if (sync_req) begin
            st_d = ST_SYNC;
        end else begin
            unique case (st_q)
                ST_SYNC: begin
                    dly_d = cfg_ila_dly;
                    mf_d  = '0;
                    st_d  = cfg_ila_skip ? ST_DATA : ST_WAIT;
                end
                ST_WAIT: begin
                    if (mf_last) begin
                        if (dly_q == '0) begin
                            st_d = ST_ILA;
                            mf_d = '0;
                        end else begin
                            dly_d = dly_q - 1'b1;
                        end
                    end
                end
                ST_ILA: begin
                    if (mf_last) begin
                        if (mf_q == MF_W'(ILA_MF - 1)) st_d = ST_DATA;
                        else                           mf_d = mf_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    st_d = ST_DATA;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_SYNC;
            dly_q <= '0;
            mf_q  <= '0;
        end else begin
            st_q  <= st_d;
            dly_q <= dly_d;
            mf_q  <= mf_d;
        end
    end

    // Output selection from the current state, then one register stage.
    always_comb begin
        unique case (st_q)
            ST_SYNC, ST_WAIT: begin
                if (cfg_alt_comma && oct_idx[0]) begin
                    oct_d = CH_ALT_TAIL;
                    isk_d = 1'b0;
                end else begin
                    oct_d = CH_COMMA;
                    isk_d = 1'b1;
                end
            end
            ST_ILA: begin
                oct_d = ila_octet;
                isk_d = ila_is_k;
            end
            ST_DATA: begin
                oct_d = in_octet;
                isk_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_octet <= CH_COMMA;
            tx_is_k  <= 1'b1;
        end else begin
            tx_octet <= oct_d;
            tx_is_k  <= isk_d;
        end
    end
endmodule

// File: rtl/jesd_link_seq_chk.sv
module jesd_link_seq_chk #(
    parameter int FRM_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               sync_req,
    input logic               sysref,
    input logic [7:0]         in_octet,
    input logic               cfg_lmfc_force,
    input logic [FRM_W-1:0]   cfg_lmfc_init,
    input logic [7:0]         tx_octet,
    input logic               tx_is_k,
    input jls_pkg::jls_state_e st_q,
    input logic [1:0]         oct_idx,
    input logic [FRM_W-1:0]   frm_idx
);
    import jls_pkg::*;

    p_comma_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(sync_req, 2) && $past(sync_req)) |->
            ((tx_is_k && tx_octet == CH_COMMA) || (!tx_is_k && tx_octet == CH_ALT_TAIL)));

    p_sync_resume_r3: assert property (@(posedge clk) disable iff (rst)
        $past(sync_req) |-> (st_q == ST_SYNC));

    p_sysref_zero_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(sysref) && !$past(cfg_lmfc_force)) |-> (frm_idx == '0 && oct_idx == 2'd0));

    p_sysref_load_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(sysref) && $past(cfg_lmfc_force)) |-> (frm_idx == $past(cfg_lmfc_init) && oct_idx == 2'd0));

    p_wait_comma_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT) |=>
            ((tx_is_k && tx_octet == CH_COMMA) || (!tx_is_k && tx_octet == CH_ALT_TAIL)));

    p_ila_open_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && st_q == ST_ILA && $past(st_q) != ST_ILA) |=> (tx_is_k && tx_octet == CH_MF_START));

    p_kcode_set_r7: assert property (@(posedge clk) disable iff (rst)
        tx_is_k |-> (tx_octet == CH_COMMA || tx_octet == CH_MF_START ||
                     tx_octet == CH_MF_END || tx_octet == CH_CFG_MARK));

    p_data_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA) |=> (!tx_is_k && tx_octet == $past(in_octet)));
endmodule

bind jesd_link_seq jesd_link_seq_chk #(.FRM_W(FRM_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .sync_req       (sync_req),
    .sysref         (sysref),
    .in_octet       (in_octet),
    .cfg_lmfc_force (cfg_lmfc_force),
    .cfg_lmfc_init  (cfg_lmfc_init),
    .tx_octet       (tx_octet),
    .tx_is_k        (tx_is_k),
    .st_q           (st_q),
    .oct_idx        (oct_idx),
    .frm_idx        (frm_idx)
);

// File: tb/jesd_link_seq_tb_top.sv
`timescale 1ns/1ps
module jesd_link_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_req = 1'b1;
    logic       sysref = 1'b0;
    logic [7:0] in_octet = 8'h00;
    logic       cfg_f_quad = 1'b0;
    logic [4:0] cfg_k_m1 = 5'd7;
    logic       cfg_lmfc_force = 1'b0;
    logic [4:0] cfg_lmfc_init = 5'd0;
    logic [1:0] cfg_ila_dly = 2'd0;
    logic       cfg_ila_skip = 1'b0;
    logic       cfg_alt_comma = 1'b0;
    logic [7:0] cfg_dev_id = 8'h5A;
    logic [4:0] cfg_lane_id = 5'd3;
    logic [7:0] tx_octet;
    logic       tx_is_k;

    always #4 clk = ~clk;

    jesd_link_seq dut_i (
        .clk(clk), .rst(rst), .sync_req(sync_req), .sysref(sysref), .in_octet(in_octet),
        .cfg_f_quad(cfg_f_quad), .cfg_k_m1(cfg_k_m1), .cfg_lmfc_force(cfg_lmfc_force),
        .cfg_lmfc_init(cfg_lmfc_init), .cfg_ila_dly(cfg_ila_dly), .cfg_ila_skip(cfg_ila_skip),
        .cfg_alt_comma(cfg_alt_comma), .cfg_dev_id(cfg_dev_id), .cfg_lane_id(cfg_lane_id),
        .tx_octet(tx_octet), .tx_is_k(tx_is_k)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string scen_tag = "R1";

    // Reference model state (bench's own reading of the requirements)
    int         m_oct, m_frm, m_st, m_dly, m_mf;
    logic [7:0] exp_oct;
    logic       exp_k;
    string      exp_tag;
    int         mf_len, k_val, f_val, pos;
    bit         at_last;

    function automatic int eff_k(input bit quad, input int km1);
        int kk = km1 + 1;
        int kmin = quad ? 8 : 9;
        return (kk < kmin) ? kmin : kk;
    endfunction

    function automatic logic [7:0] cfg_octet(input int idx, input int f, input int k);
        logic [7:0] s;
        s = cfg_dev_id + 8'(cfg_lane_id) + 8'(f - 1) + 8'(k - 1);
        case (idx)
            0:  return cfg_dev_id;
            1:  return 8'(cfg_lane_id);
            2:  return 8'(f - 1);
            3:  return 8'(k - 1);
            13: return s;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_oct = 0; m_frm = 0; m_st = 0; m_dly = 0; m_mf = 0;
            exp_oct = 8'hBC; exp_k = 1'b1; exp_tag = "R1";
        end else begin
            f_val   = cfg_f_quad ? 4 : 2;
            k_val   = eff_k(cfg_f_quad, int'(cfg_k_m1));
            mf_len  = f_val * k_val;
            at_last = (m_oct >= f_val - 1) && (m_frm >= k_val - 1);
            pos     = m_frm * f_val + (m_oct % f_val);
            case (m_st)
                0, 1: begin
                    exp_tag = (m_st == 0) ? "R2" : "R6";
                    if (cfg_alt_comma && (m_oct % 2 == 1)) begin exp_oct = 8'h50; exp_k = 1'b0; end
                    else begin exp_oct = 8'hBC; exp_k = 1'b1; end
                end
                2: begin
                    exp_tag = (m_mf == 1 && pos >= 1 && pos <= 15) ? "R8" : "R7";
                    if (pos == 0) begin exp_oct = 8'h1C; exp_k = 1'b1; if (m_mf == 0) exp_tag = "R6"; end
                    else if (at_last) begin exp_oct = 8'h7C; exp_k = 1'b1; end
                    else if (m_mf == 1 && pos == 1) begin exp_oct = 8'h9C; exp_k = 1'b1; end
                    else if (m_mf == 1 && pos >= 2 && pos <= 15) begin exp_oct = cfg_octet(pos - 2, f_val, k_val); exp_k = 1'b0; end
                    else begin exp_oct = 8'(pos); exp_k = 1'b0; end
                end
                default: begin exp_tag = "R9"; exp_oct = in_octet; exp_k = 1'b0; end
            endcase
            // state advance
            if (sync_req) m_st = 0;
            else if (m_st == 0) begin
                m_dly = int'(cfg_ila_dly); m_mf = 0;
                m_st = cfg_ila_skip ? 3 : 1;
            end else if (m_st == 1 && at_last) begin
                if (m_dly == 0) begin m_st = 2; m_mf = 0; end else m_dly = m_dly - 1;
            end else if (m_st == 2 && at_last) begin
                if (m_mf == 3) m_st = 3; else m_mf = m_mf + 1;
            end
            // LMFC advance
            if (sysref) begin
                m_oct = 0; m_frm = cfg_lmfc_force ? int'(cfg_lmfc_init) : 0;
            end else if (m_oct >= f_val - 1) begin
                m_oct = 0; m_frm = (m_frm >= k_val - 1) ? 0 : m_frm + 1;
            end else m_oct = m_oct + 1;
        end
    end

    task automatic compare();
        n_chk++;
        if (tx_octet !== exp_oct || tx_is_k !== exp_k) begin
            n_bad++;
            $display("FAIL %s (scenario %s) t=%0t actual octet=%h k=%b expected octet=%h k=%b",
                     exp_tag, scen_tag, $time, tx_octet, tx_is_k, exp_oct, exp_k);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            in_octet = 8'($urandom);
        end
    endtask

    task automatic scenario(input string tag, input bit quad, input int km1, input int dly,
                            input bit skip, input bit alt, input bit frc, input int init,
                            input int cut_at);
        int run_len;
        scen_tag = tag;
        sync_req = 1'b1;
        step(3);
        cfg_f_quad = quad; cfg_k_m1 = 5'(km1); cfg_ila_dly = 2'(dly);
        cfg_ila_skip = skip; cfg_alt_comma = alt; cfg_lmfc_force = frc;
        cfg_lmfc_init = 5'(init);
        step(2);
        sysref = 1'b1;
        step(1);
        sysref = 1'b0;
        step(4 + int'($urandom % 23));
        sync_req = 1'b0;
        run_len = (dly + 6) * eff_k(quad, km1) * (quad ? 4 : 2) + 20;
        if (cut_at > 0) begin
            step(cut_at);
            sync_req = 1'b1;   // reassertion mid-sequence
            step(6);
            sync_req = 1'b0;
        end
        step(run_len);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        n_chk++;
        if (tx_octet !== 8'hBC || tx_is_k !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 reset actual octet=%h k=%b expected octet=bc k=1", tx_octet, tx_is_k);
        end
        rst = 1'b0;
        step(1);
        // Directed corner cases
        scenario("R4", 1'b0, 7, 0, 1'b0, 1'b0, 1'b0, 0, 0);   // K floor 9 at F=2
        scenario("R4", 1'b1, 3, 0, 1'b0, 1'b0, 1'b0, 0, 0);   // K floor 8 at F=4
        scenario("R6", 1'b0, 10, 3, 1'b0, 1'b0, 1'b0, 0, 0);  // longest delay
        scenario("R5", 1'b0, 8, 1, 1'b0, 1'b0, 1'b1, 5, 0);   // forced preset
        scenario("R2", 1'b1, 9, 0, 1'b0, 1'b1, 1'b0, 0, 0);   // 0xBC50 code word
        scenario("R10", 1'b0, 8, 2, 1'b1, 1'b0, 1'b0, 0, 0);  // ILA skipped
        scenario("R3", 1'b0, 8, 0, 1'b0, 1'b0, 1'b0, 0, 45);  // reassert during ILA
        // Constrained random
        for (int it = 0; it < 14; it++) begin
            scenario((it % 2 == 0) ? "R7" : "R8", 1'($urandom % 2), int'($urandom % 20),
                     int'($urandom % 4), ($urandom % 5 == 0), 1'($urandom % 2),
                     1'($urandom % 2), int'($urandom % 8),
                     ($urandom % 3 == 0) ? int'(10 + $urandom % 120) : 0);
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule